// File: doc/BRIEF.md
# System Clock Source Selector and Divider

This block chooses which of several free-running oscillator signals clocks the core and the peripherals. It divides the chosen source, and it watches an external clock input for loss. All logic runs on one fast sampling clock. Each oscillator arrives as a slow toggling input and is synchronized, and its rising edges are detected. The block does not produce clocks. It produces single-cycle enables: a core enable once per divided period, and a peripheral enable at a fixed sub-rate.

Software programs two 4-bit registers through a shared write-data nibble. The control register holds a keep-running flag for sleep, a source override that forces the internal RC oscillator, and a two-bit divide code. The configuration register holds a two-bit source code.

Every register write starts a changeover. The old divided period runs to its end. The new source must then show two edges before counting starts again, so no enable period is ever cut short. The block also drives stop requests for the oscillators. A supervisor raises a reset when the external clock goes silent, but only while the external clock is the programmed core source.

Top module: `clksel_sysclk`

## Requirements
- R1: After reset the control register holds 1111b and the source code is 11b. The core enable then comes from the RC 1 input divided by 8, and all stop outputs are 0.
- R2: Control bits [1:0] set the core divide ratio: 00 gives ÷16, 11 gives ÷8, 10 gives ÷4 and 01 gives ÷2. In steady state, core enables are spaced by ratio × source period.
- R3: Control bit 2 = 1 selects RC 1. When it is 0, configuration bits [1:0] select the source: 11 external, 01 RC 2, 10 fast crystal, 00 low-frequency crystal. Configuration bits [3:2] are ignored.
- R4: In steady state the peripheral enable pulses once per 16 edges of the undivided selected source. When the source code is 00, it pulses once per low-frequency crystal edge instead.
- R5: After any register write, the enable that ends the divided period in progress still arrives exactly one old period after the previous enable.
- R6: After that enable, the new settings apply. Two edges of the new source pass uncounted, so the next enable comes after between ratio+1 and ratio+2 new source periods.
- R7: The supervisor reset can be high only while the source code is 11 and control bit 2 is 0. In every other mode it stays low however long the external input is silent.
- R8: In the supervised mode, the supervisor reset rises once the external input has had no edge for more than TIMEOUT_CYC sampling cycles. It falls in the cycle after the next external edge.
- R9: The stop outputs are registered. Bit 0 stops RC 1, bit 1 stops RC 2, bit 2 stops the fast crystal and bit 3 stops the external input. When sleep is high and control bit 3 is 0, all four bits are 1. The low-frequency crystal is never stopped.
- R10: While control bit 2 is 0, stop bit 0 (RC 1) is 1.
- R11: Each core and peripheral enable is high for exactly one sampling cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_rc1 | input | 1 | Internal RC oscillator 1 |
| osc_rc2 | input | 1 | Trimmed RC oscillator 2 |
| osc_xtal | input | 1 | Fast crystal oscillator |
| osc_lf | input | 1 | Low-frequency crystal oscillator |
| osc_ext | input | 1 | External clock input |
| sleep | input | 1 | Core sleep indication |
| cm_we | input | 1 | Write strobe for the control register |
| sc_we | input | 1 | Write strobe for the configuration register |
| wdata | input | 4 | Register write data |
| core_ce | output | 1 | Core clock enable pulse |
| peri_ce | output | 1 | Peripheral clock enable pulse |
| osc_stop | output | 4 | Stop requests: [0] RC 1, [1] RC 2, [2] fast crystal, [3] external |
| sup_rst | output | 1 | Supervisor reset on missing external clock |

## Verification
Some rules can be checked on every cycle: the single-cycle width of both enables, the mode gating of the supervisor reset, its clearing on an external edge, and the stop mapping for sleep and the RC override. Other behaviour spans many cycles and depends on the relative phase of slow sources. The bench scenarios must show it: divided spacings for each ratio and source, the peripheral sub-rate, the exact end of the old period across a write, the two-edge settling gap, and the timeout length.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_WAIT_OLD = 2'd1,
    ST_WAIT_NEW = 2'd2
  } chg_state_t;

  localparam int NSRC    = 5;
  localparam int SRC_RC1 = 0;
  localparam int SRC_RC2 = 1;
  localparam int SRC_XT  = 2;
  localparam int SRC_LF  = 3;
  localparam int SRC_EXT = 4;

  // terminal count of the core divider for a divide code
  function automatic logic [3:0] core_last(input logic [1:0] code);
    case (code)
      2'b00:   core_last = 4'd15;
      2'b01:   core_last = 4'd1;
      2'b10:   core_last = 4'd3;
      default: core_last = 4'd7;
    endcase
  endfunction

  // source index chosen by the override bit and the source code
  function automatic logic [2:0] src_pick(input logic rc_force, input logic [1:0] code);
    if (rc_force) src_pick = 3'(SRC_RC1);
    else begin
      case (code)
        2'b11:   src_pick = 3'(SRC_EXT);
        2'b01:   src_pick = 3'(SRC_RC2);
        2'b10:   src_pick = 3'(SRC_XT);
        default: src_pick = 3'(SRC_LF);
      endcase
    end
  endfunction

endpackage

// File: rtl/clksel_edge_sync.sv
module clksel_edge_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      logic [STAGES:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in[g]};
      end
      assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
    end
  endgenerate
endmodule

// File: rtl/clksel_core_div.sv
module clksel_core_div
  import clksel_pkg::*;
#(
  parameter int PERI_DIV = 16,
  parameter int SETTLE   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_rise,
  input  logic            req,
  input  logic            prog_rc,
  input  logic [1:0]      prog_div,
  input  logic [1:0]      prog_src,
  output logic            core_ce,
  output logic            peri_ce
);
  localparam int PW = $clog2(PERI_DIV);
  localparam int SW = $clog2(SETTLE + 1);

  chg_state_t    state;
  logic          app_rc;
  logic [1:0]    app_div;
  logic [1:0]    app_src;
  logic [3:0]    cnt;
  logic [PW-1:0] pcnt;
  logic [SW-1:0] scnt;

  logic [2:0] sel;
  logic       cin_edge, term, apply_now, peri_edge, lf_mode;

  always_comb begin
    sel       = src_pick(app_rc, app_src);
    cin_edge  = src_rise[sel];
    term      = (state != ST_WAIT_NEW) && cin_edge && (cnt == core_last(app_div));
    apply_now = (state == ST_WAIT_NEW) ? req
                                       : (term && (req || state == ST_WAIT_OLD));
    lf_mode   = (app_src == 2'b00);
    peri_edge = lf_mode ? src_rise[SRC_LF] : cin_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      app_rc  <= 1'b1;
      app_div <= 2'b11;
      app_src <= 2'b11;
      cnt     <= '0;
      scnt    <= '0;
      core_ce <= 1'b0;
    end else begin
      core_ce <= term;
      if (apply_now) begin
        app_rc  <= prog_rc;
        app_div <= prog_div;
        app_src <= prog_src;
        scnt    <= '0;
        cnt     <= '0;
        state   <= ST_WAIT_NEW;
      end else begin
        case (state)
          ST_RUN, ST_WAIT_OLD: begin
            if (cin_edge) cnt <= term ? 4'd0 : cnt + 4'd1;
            if (req) state <= ST_WAIT_OLD;
          end
          ST_WAIT_NEW: begin
            if (cin_edge) begin
              if (scnt == SW'(SETTLE - 1)) begin
                state <= ST_RUN;
                cnt   <= '0;
              end else begin
                scnt <= scnt + 1'b1;
              end
            end
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      peri_ce <= 1'b0;
    end else begin
      peri_ce <= 1'b0;
      if (apply_now) pcnt <= '0;
      else if (peri_edge) begin
        if (lf_mode) peri_ce <= 1'b1;
        else if (pcnt == PW'(PERI_DIV - 1)) begin
          pcnt    <= '0;
          peri_ce <= 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clksel_supervisor.sv
module clksel_supervisor #(
  parameter int TIMEOUT_CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ext_rise,
  output logic sup_rst
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  logic [CW-1:0] silent;

  always_ff @(posedge clk) begin
    if (rst) begin
      silent  <= '0;
      sup_rst <= 1'b0;
    end else begin
      if (!en || ext_rise)                 silent <= '0;
      else if (silent != CW'(TIMEOUT_CYC)) silent <= silent + 1'b1;
      sup_rst <= en && !ext_rise && (silent == CW'(TIMEOUT_CYC));
    end
  end
endmodule

// File: rtl/clksel_sysclk.sv
module clksel_sysclk
  import clksel_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250000,
  parameter int PERI_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_rc1,
  input  logic       osc_rc2,
  input  logic       osc_xtal,
  input  logic       osc_lf,
  input  logic       osc_ext,
  input  logic       sleep,
  input  logic       cm_we,
  input  logic       sc_we,
  input  logic [3:0] wdata,
  output logic       core_ce,
  output logic       peri_ce,
  output logic [3:0] osc_stop,
  output logic       sup_rst
);
  logic       keep_q, rc_q, req_q;
  logic [1:0] div_q, src_q;
  logic [NSRC-1:0] src_rise;
  logic       halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q <= 1'b1;
      rc_q   <= 1'b1;
      div_q  <= 2'b11;
      src_q  <= 2'b11;
      req_q  <= 1'b0;
    end else begin
      if (cm_we) {keep_q, rc_q, div_q} <= wdata;
      if (sc_we) src_q <= wdata[1:0];
      req_q <= cm_we | sc_we;
    end
  end

  assign halt = sleep && !keep_q;

  always_ff @(posedge clk) begin
    if (rst) osc_stop <= '0;
    else     osc_stop <= {halt, halt, halt, halt || !rc_q};
  end

  clksel_edge_sync #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({osc_ext, osc_lf, osc_xtal, osc_rc2, osc_rc1}),
    .rise     (src_rise)
  );

  clksel_core_div #(.PERI_DIV(PERI_DIV), .SETTLE(2)) u_div (
    .clk      (clk),
    .rst      (rst),
    .src_rise (src_rise),
    .req      (req_q),
    .prog_rc  (rc_q),
    .prog_div (div_q),
    .prog_src (src_q),
    .core_ce  (core_ce),
    .peri_ce  (peri_ce)
  );

  clksel_supervisor #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_sup (
    .clk      (clk),
    .rst      (rst),
    .en       (src_q == 2'b11 && !rc_q),
    .ext_rise (src_rise[SRC_EXT]),
    .sup_rst  (sup_rst)
  );
endmodule

// File: rtl/clksel_sysclk_chk.sv
module clksel_sysclk_chk (
  input logic       clk,
  input logic       rst,
  input logic       core_ce,
  input logic       peri_ce,
  input logic       sup_rst,
  input logic [3:0] osc_stop,
  input logic       sleep,
  input logic       keep_q,
  input logic       rc_q,
  input logic [1:0] src_q,
  input logic       ext_rise
);
  AST_CORE_SINGLE: assert property (@(posedge clk) disable iff (rst) core_ce |=> !core_ce); // R11
  AST_PERI_SINGLE: assert property (@(posedge clk) disable iff (rst) peri_ce |=> !peri_ce); // R11
  AST_SUP_MODE: assert property (@(posedge clk) disable iff (rst) sup_rst |-> $past(src_q == 2'b11 && !rc_q)); // R7
  AST_SUP_CLEAR: assert property (@(posedge clk) disable iff (rst) ext_rise |=> !sup_rst); // R8
  AST_RC1_STOP: assert property (@(posedge clk) disable iff (rst) !rc_q |=> osc_stop[0]); // R10
  AST_HALT_ALL: assert property (@(posedge clk) disable iff (rst) (sleep && !keep_q) |=> (osc_stop == 4'b1111)); // R9
  AST_AWAKE_NONE: assert property (@(posedge clk) disable iff (rst) (!sleep && rc_q) |=> (osc_stop == 4'b0000)); // R9
endmodule

bind clksel_sysclk clksel_sysclk_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .core_ce  (core_ce),
  .peri_ce  (peri_ce),
  .sup_rst  (sup_rst),
  .osc_stop (osc_stop),
  .sleep    (sleep),
  .keep_q   (keep_q),
  .rc_q     (rc_q),
  .src_q    (src_q),
  .ext_rise (src_rise[4])
);

// File: tb/clksel_sysclk_bench.sv
`timescale 1ns/1ps
module clksel_sysclk_bench;
  localparam int TO = 300;
  logic clk = 1'b0, rst = 1'b1;
  logic osc_rc1 = 0, osc_rc2 = 0, osc_xtal = 0, osc_lf = 0, osc_ext = 0;
  logic sleep = 0, cm_we = 0, sc_we = 0;
  logic [3:0] wdata = '0;
  logic core_ce, peri_ce, sup_rst;
  logic [3:0] osc_stop;
  bit ext_run = 1'b1;
  int cyc = 0, n_chk = 0, n_fail = 0;
  int h1 = 0, h2 = 0, h3 = 0, h4 = 0, h5 = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // half periods 3,5,2,11,4 -> full periods 6,10,4,22,8
  always @(negedge clk) begin
    if (h1 == 2)  begin h1 <= 0; osc_rc1  <= ~osc_rc1;  end else h1 <= h1 + 1;
    if (h2 == 4)  begin h2 <= 0; osc_rc2  <= ~osc_rc2;  end else h2 <= h2 + 1;
    if (h3 == 1)  begin h3 <= 0; osc_xtal <= ~osc_xtal; end else h3 <= h3 + 1;
    if (h4 == 10) begin h4 <= 0; osc_lf   <= ~osc_lf;   end else h4 <= h4 + 1;
    if (ext_run) begin
      if (h5 == 3) begin h5 <= 0; osc_ext <= ~osc_ext; end else h5 <= h5 + 1;
    end
  end

  clksel_sysclk #(.TIMEOUT_CYC(TO)) u_clksel_sysclk (
    .clk(clk), .rst(rst), .osc_rc1(osc_rc1), .osc_rc2(osc_rc2), .osc_xtal(osc_xtal),
    .osc_lf(osc_lf), .osc_ext(osc_ext), .sleep(sleep), .cm_we(cm_we), .sc_we(sc_we),
    .wdata(wdata), .core_ce(core_ce), .peri_ce(peri_ce), .osc_stop(osc_stop), .sup_rst(sup_rst)
  );

  function automatic int ratio(input logic [1:0] c);
    case (c) 2'b00: return 16; 2'b11: return 8; 2'b10: return 4; default: return 2; endcase
  endfunction
  function automatic int per(input logic rc, input logic [1:0] s);
    if (rc) return 6;
    case (s) 2'b11: return 8; 2'b01: return 10; 2'b10: return 4; default: return 22; endcase
  endfunction
  function automatic int pgap(input logic rc, input logic [1:0] s);
    return (s == 2'b00) ? 22 : 16 * per(rc, s);
  endfunction

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr_cm(input logic [3:0] v);
    @(negedge clk); cm_we = 1; wdata = v; @(negedge clk); cm_we = 0;
  endtask
  task automatic wr_sc(input logic [3:0] v);
    @(negedge clk); sc_we = 1; wdata = v; @(negedge clk); sc_we = 0;
  endtask
  task automatic wait_core(output int t);
    do @(negedge clk); while (!core_ce);
    t = cyc;
  endtask
  task automatic wait_peri(output int t);
    do @(negedge clk); while (!peri_ce);
    t = cyc;
  endtask
  task automatic core_gap(output int g);
    int a, b;
    wait_core(a); wait_core(a); wait_core(a); wait_core(b);
    g = b - a;
  endtask
  task automatic peri_gap(output int g);
    int a, b;
    wait_peri(a); wait_peri(a); wait_peri(b);
    g = b - a;
  endtask
  task automatic quiet(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (sup_rst) seen = 1; end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  initial begin
    int g, t0, t1, t2;
    bit seen;
    logic [1:0] dv, sv;
    logic rcv;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(osc_stop == 4'b0000 && !core_ce && !peri_ce && !sup_rst, "R1 reset outputs", int'(osc_stop), 0);
    core_gap(g); check(g == 48, "R1 default core spacing", g, 48);
    peri_gap(g); check(g == 96, "R4 default peripheral spacing", g, 96);

    wr_cm(4'b1100); core_gap(g); check(g == 96, "R2 div16", g, 96);
    wr_cm(4'b1110); core_gap(g); check(g == 24, "R2 div4", g, 24);
    wr_cm(4'b1101); core_gap(g); check(g == 12, "R2 div2", g, 12);

    wr_sc(4'b1101); wr_cm(4'b1011); core_gap(g); check(g == 80, "R3 rc2 source, bits 3:2 ignored", g, 80);
    @(negedge clk); check(osc_stop[0] == 1'b1, "R10 rc1 stopped", int'(osc_stop), 1);
    wr_sc(4'b0010); core_gap(g); check(g == 32, "R3 fast crystal", g, 32);
    wr_sc(4'b0000); core_gap(g); check(g == 176, "R3 lf crystal", g, 176);
    peri_gap(g); check(g == 22, "R4 lf peripheral", g, 22);
    wr_sc(4'b0011); core_gap(g); check(g == 64, "R3 external", g, 64);

    wait_core(t0);
    repeat (10) @(negedge clk);
    wr_cm(4'b1101);
    wait_core(t1); check(t1 - t0 == 64, "R5 old period completes", t1 - t0, 64);
    wait_core(t2); check(t2 - t1 >= 18 && t2 - t1 <= 24, "R6 settle gap", t2 - t1, 18);
    wait_core(t0); check(t0 - t2 == 12, "R6 steady after change", t0 - t2, 12);

    wr_cm(4'b1011); core_gap(g);
    quiet(3 * TO, seen); check(!seen, "R7 no reset with clock present", int'(seen), 0);
    ext_run = 0;
    quiet(TO - 20, seen); check(!seen, "R8 no early timeout", int'(seen), 0);
    repeat (40) @(negedge clk);
    check(sup_rst == 1'b1, "R8 timeout raises reset", int'(sup_rst), 1);
    ext_run = 1;
    repeat (20) @(negedge clk);
    check(sup_rst == 1'b0, "R8 edge clears reset", int'(sup_rst), 0);

    wr_cm(4'b1111); core_gap(g);
    ext_run = 0; quiet(2 * TO, seen); ext_run = 1;
    check(!seen, "R7 override mode unsupervised", int'(seen), 0);
    wr_sc(4'b0001); wr_cm(4'b1011); core_gap(g);
    ext_run = 0; quiet(2 * TO, seen); ext_run = 1;
    check(!seen, "R7 rc2 mode unsupervised", int'(seen), 0);

    sleep = 1; repeat (3) @(negedge clk);
    check(osc_stop == 4'b0001, "R9 sleep with keep-running", int'(osc_stop), 1);
    wr_cm(4'b0011); repeat (2) @(negedge clk);
    check(osc_stop == 4'b1111, "R9 sleep stops all", int'(osc_stop), 15);
    sleep = 0; repeat (2) @(negedge clk);
    check(osc_stop == 4'b0001, "R10 awake, override off", int'(osc_stop), 1);
    wr_cm(4'b1111); repeat (2) @(negedge clk);
    check(osc_stop == 4'b0000, "R9 awake with override", int'(osc_stop), 0);

    void'($urandom(32'd1234));
    for (int k = 0; k < 20; k++) begin
      dv = 2'($urandom); sv = 2'($urandom); rcv = 1'($urandom);
      wr_sc({2'($urandom), sv});
      wr_cm({1'b1, rcv, dv});
      core_gap(g);
      check(g == ratio(dv) * per(rcv, sv), "R2 R3 random core spacing", g, ratio(dv) * per(rcv, sv));
      peri_gap(g);
      check(g == pgap(rcv, sv), "R4 random peripheral spacing", g, pgap(rcv, sv));
      check(osc_stop[0] == !rcv, "R10 random stop bit", int'(osc_stop[0]), int'(!rcv));
    end
    finish_run();
  end
endmodule